// File: doc/BRIEF.md
# Dual 8-bit Pulse-Width Modulator with 16-bit Cascade

This block produces two pulse-width modulated outputs from two independent 8-bit counter channels. Each channel is given a period length, an active-time (duty) count and an output polarity through a small write-only register port. A single control bit joins the two channels into one 16-bit channel: the period and duty values of both channels are then read as the low and high bytes of 16-bit values, the first output carries the waveform and the second output rests at its inactive level.

Counting is gated by a clock-enable input, so an external divider sets the time base. Period and duty values are held in staging registers and copied into the running channel only when a new period starts, or at any time while the channel is disabled. The waveform therefore never sees a half-updated setting. Every duty value is exact: zero gives a steady inactive output, and a value equal to or above the period gives a steady active output.

Top module: `dual_pwm`

## Requirements
- R1: A synchronous active-low reset clears every register, so both outputs read 0 on the first clock edge after reset is taken and stay 0 until the block is reprogrammed.
- R2: A running 8-bit channel with period value P counts P enabled ticks per period (counter 0 to P-1). A period value of 0 is taken as a length of one tick.
- R3: With duty value D, the channel is active for the first D ticks of each period. D = 0 keeps the output at its inactive level, and any nonzero D at or above P keeps it at its active level. `pwm_o` is registered and shows the counter state of the previous clock.
- R4: Counters advance only on clocks where `clk_en` is 1. While `clk_en` is 0 the counters and the outputs hold.
- R5: Polarity bit 0 gives an active-high output and polarity bit 1 an active-low output. A disabled channel drives its inactive level, which is the value of its polarity bit.
- R6: Writes to period or duty go to staging registers. A running channel copies them only when its counter wraps, so the period in progress completes with the old values. A disabled channel copies them on every clock.
- R7: With the cascade bit set, period = {reg 2, reg 0} and duty = {reg 3, reg 1} drive one 16-bit channel with the same timing rules as R2 and R3. It is enabled by enable bit 0, uses polarity bit 0 and comes out on `pwm_o[0]`. `pwm_o[1]` is held at the value of polarity bit 1.
- R8: Outside cascade mode the two channels run independently, each with its own period, duty, enable and polarity.
- R9: Register map for `wr_addr`: 0 is the channel 0 period, 1 the channel 0 duty, 2 the channel 1 period, 3 the channel 1 duty. Address 4 is control: bit 0 enables channel 0, bit 1 enables channel 1, bit 2 is the channel 0 polarity, bit 3 the channel 1 polarity and bit 4 the cascade mode. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Counter tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | CH_W (8) | Register write data |
| pwm_o | output | 2 | PWM outputs, bit 0 for channel 0 or the cascaded channel, bit 1 for channel 1 |

## Verification
On every clock, the assertions check that a disabled channel and the parked second output sit at their polarity level. They check that counters stay inside their period, that counters freeze without a tick, and that a zero or saturating duty produces a steady level. Other properties depend on a whole period or on a history of writes: the exact active count per period, the period length, the deferral of new settings to the next wrap, the byte order of the 16-bit cascade and the silence of unused addresses. Only the bench's scenarios can show these, by comparing every output sample with a reference model and by counting active samples over windows of whole periods.

// File: rtl/dual_pwm_pkg.sv
// Package: shared constants and the control-register layout of the dual PWM.
// Assumes a 3-bit register address; the map below is the software contract.
package dual_pwm_pkg;

    localparam int unsigned NUM_CH  = 2;

    // Register addresses
    localparam int unsigned A_PER0  = 0;
    localparam int unsigned A_DUTY0 = 1;
    localparam int unsigned A_PER1  = 2;
    localparam int unsigned A_DUTY1 = 3;
    localparam int unsigned A_CTRL  = 4;

    // Control register: packed so that en sits in bits 1:0, pol in 3:2, casc in 4
    typedef struct packed {
        logic              casc;
        logic [NUM_CH-1:0] pol;
        logic [NUM_CH-1:0] en;
    } pwm_ctrl_t;

    localparam int unsigned CTRL_W = $bits(pwm_ctrl_t);

endpackage

// File: rtl/dual_pwm_regs.sv
// Module: staging register file of the dual PWM.
// Holds per-channel period and duty staging values plus the control word.
// Assumes single-cycle writes; addresses outside the map are dropped.
module dual_pwm_regs
    import dual_pwm_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CH_W-1:0]               wr_data,
    output logic [NUM_CH-1:0][CH_W-1:0]   sh_per,
    output logic [NUM_CH-1:0][CH_W-1:0]   sh_duty,
    output pwm_ctrl_t                     ctrl
);

    logic [NUM_CH-1:0][CH_W-1:0] per_q;
    logic [NUM_CH-1:0][CH_W-1:0] duty_q;
    pwm_ctrl_t                   ctrl_q;

    // Purpose: capture software writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_PER0):  per_q[0]  <= wr_data;
                ADDR_W'(A_DUTY0): duty_q[0] <= wr_data;
                ADDR_W'(A_PER1):  per_q[1]  <= wr_data;
                ADDR_W'(A_DUTY1): duty_q[1] <= wr_data;
                ADDR_W'(A_CTRL):  ctrl_q    <= pwm_ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    assign sh_per  = per_q;
    assign sh_duty = duty_q;
    assign ctrl    = ctrl_q;

endmodule

// File: rtl/pwm_slice.sv
// Module: one PWM counter channel of width W.
// Counts enabled ticks from 0 to per-1, then wraps and reloads period and duty
// from the staging inputs. While not running it is parked at zero and loads
// the staging values on every clock. The output is active while cnt < duty,
// which makes duty 0 steady inactive and duty >= per steady active.
module pwm_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] shd_per,
    input  logic [W-1:0] shd_duty,
    output logic         active_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] per_o,
    output logic [W-1:0] duty_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic [W-1:0] duty_q;
    logic [W:0]   cnt_inc;
    logic         last;

    // Purpose: detect the final tick of the current period (per 0 means length 1).
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
        last    = (per_q == '0) || (cnt_inc >= {1'b0, per_q});
    end

    // Purpose: advance the counter and reload the active settings at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            per_q  <= shd_per;
            duty_q <= shd_duty;
        end else if (tick) begin
            if (last) begin
                cnt_q  <= '0;
                per_q  <= shd_per;
                duty_q <= shd_duty;
            end else begin
                cnt_q  <= cnt_inc[W-1:0];
            end
        end
    end

    assign active_o = (cnt_q < duty_q);
    assign cnt_o    = cnt_q;
    assign per_o    = per_q;
    assign duty_o   = duty_q;

endmodule

// File: rtl/pwm_outstage.sv
// Module: output register stage of the dual PWM.
// Applies enable, polarity and cascade selection to the raw compare results
// and registers the result so the pins cannot glitch.
// Assumes nact[i] comes from narrow channel i and wact from the cascaded one.
module pwm_outstage
    import dual_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pwm_ctrl_t         ctrl,
    input  logic [NUM_CH-1:0] nact,
    input  logic              wact,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] drive;
    logic [NUM_CH-1:0] pwm_q;

    // Purpose: choose the compare result feeding each pin.
    always_comb begin
        raw[0]   = ctrl.casc ? wact : nact[0];
        raw[1]   = nact[1];
        drive[0] = ctrl.en[0];
        drive[1] = ctrl.en[1] && !ctrl.casc;
    end

    // Purpose: register each pin, inactive level equal to its polarity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                pwm_q[i] <= drive[i] ? (raw[i] ^ ctrl.pol[i]) : ctrl.pol[i];
            end
        end
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/dual_pwm.sv
// Module: dual 8-bit PWM timer with optional 16-bit cascade (top level).
// Two narrow slices serve the independent mode; one wide slice, built from
// the concatenated staging registers, serves the cascade mode. The slices of
// the unused mode are held parked so they restart cleanly on a mode change.
// Assumes clk_en is synchronous to clk.
module dual_pwm
    import dual_pwm_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    output logic [1:0]        pwm_o
);

    localparam int WIDE_W = NUM_CH * CH_W;

    logic [NUM_CH-1:0][CH_W-1:0] sh_per;
    logic [NUM_CH-1:0][CH_W-1:0] sh_duty;
    pwm_ctrl_t                   ctrl;

    logic [NUM_CH-1:0]           nrun;
    logic [NUM_CH-1:0]           nact;
    logic [NUM_CH-1:0][CH_W-1:0] ncnt;
    logic [NUM_CH-1:0][CH_W-1:0] nper;
    logic [NUM_CH-1:0][CH_W-1:0] nduty;

    logic                        wrun;
    logic                        wact;
    logic [WIDE_W-1:0]           wcnt;
    logic [WIDE_W-1:0]           wper;
    logic [WIDE_W-1:0]           wduty;

    dual_pwm_regs #(
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sh_per  (sh_per),
        .sh_duty (sh_duty),
        .ctrl    (ctrl)
    );

    // Narrow channels: one slice per channel, parked in cascade mode.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_narrow
        assign nrun[g] = ctrl.en[g] && !ctrl.casc;

        pwm_slice #(
            .W (CH_W)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (clk_en),
            .run      (nrun[g]),
            .shd_per  (sh_per[g]),
            .shd_duty (sh_duty[g]),
            .active_o (nact[g]),
            .cnt_o    (ncnt[g]),
            .per_o    (nper[g]),
            .duty_o   (nduty[g])
        );
    end

    // Cascaded channel: channel 0 bytes low, channel 1 bytes high.
    assign wrun = ctrl.en[0] && ctrl.casc;

    pwm_slice #(
        .W (WIDE_W)
    ) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (clk_en),
        .run      (wrun),
        .shd_per  (sh_per),
        .shd_duty (sh_duty),
        .active_o (wact),
        .cnt_o    (wcnt),
        .per_o    (wper),
        .duty_o   (wduty)
    );

    pwm_outstage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .nact  (nact),
        .wact  (wact),
        .pwm_o (pwm_o)
    );

endmodule

// File: rtl/dual_pwm_chk.sv
// Checker: clocked properties of the dual PWM, bound into every dual_pwm.
module dual_pwm_chk #(
    parameter int CH_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en,
    input logic [1:0]            en,
    input logic [1:0]            pol,
    input logic                  casc,
    input logic [1:0]            nrun,
    input logic [1:0][CH_W-1:0]  ncnt,
    input logic [1:0][CH_W-1:0]  nper,
    input logic [1:0][CH_W-1:0]  nduty,
    input logic [2*CH_W-1:0]     wcnt,
    input logic [2*CH_W-1:0]     wper,
    input logic [2*CH_W-1:0]     wduty,
    input logic [1:0]            pwm_o
);

    // R5: a disabled first channel rests at its polarity level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] |=> (pwm_o[0] == $past(pol[0])));

    // R7: in cascade mode the second pin is parked at its polarity level
    a_r7_second_parked: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> (pwm_o[1] == $past(pol[1])));

    // R7: cascaded counter stays inside its period
    a_r7_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en[0] && casc) |-> ((wper == '0) || (wcnt < wper)));

    // R7: a saturating 16-bit duty gives a steady active level
    a_r7_wide_full: assert property (@(posedge clk) disable iff (!rst_n)
        (en[0] && casc && (wduty != '0) && (wduty >= wper)) |=> (pwm_o[0] == !$past(pol[0])));

    for (genvar g = 0; g < 2; g++) begin : g_ch
        // R4: no tick, no counter movement
        a_r4_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
            (nrun[g] && !clk_en) |=> (ncnt[g] == $past(ncnt[g])));

        // R2: counter stays inside its period
        a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            nrun[g] |-> ((nper[g] == '0) || (ncnt[g] < nper[g])));

        // R3: zero duty gives the inactive level
        a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
            (nrun[g] && (nduty[g] == '0)) |=> (pwm_o[g] == $past(pol[g])));

        // R3: duty at or above the period gives the active level
        a_r3_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
            (nrun[g] && (nduty[g] != '0) && (nduty[g] >= nper[g])) |=> (pwm_o[g] == !$past(pol[g])));
    end

endmodule

bind dual_pwm dual_pwm_chk #(
    .CH_W (CH_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .en     (ctrl.en),
    .pol    (ctrl.pol),
    .casc   (ctrl.casc),
    .nrun   (nrun),
    .ncnt   (ncnt),
    .nper   (nper),
    .nduty  (nduty),
    .wcnt   (wcnt),
    .wper   (wper),
    .wduty  (wduty),
    .pwm_o  (pwm_o)
);

// File: tb/dual_pwm_tb.sv
`timescale 1ns/1ps
module dual_pwm_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pwm_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ce_mode = 0;       // 0: high, 1: toggle, 2: random, 3: low
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_per[2], m_duty[2];
    logic [4:0] m_ctrl;
    int ncnt[2], nper[2], nduty[2];
    int wcnt, wper, wduty;
    logic [1:0] mout;

    always #4 clk = ~clk;

    dual_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    // tick-enable pattern generator
    always @(negedge clk) begin
        case (ce_mode)
            0: clk_en <= 1'b1;
            1: clk_en <= ~clk_en;
            2: clk_en <= 1'($urandom_range(0, 1));
            default: clk_en <= 1'b0;
        endcase
    end

    // reference model built from the requirements
    always @(posedge clk) begin : model
        logic [1:0] on;
        logic [1:0] en, pol;
        logic casc, act;
        int sp, sd;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_per[i] = 0; m_duty[i] = 0; ncnt[i] = 0; nper[i] = 0; nduty[i] = 0;
            end
            m_ctrl = '0; wcnt = 0; wper = 0; wduty = 0; mout = 2'b00;
        end else begin
            en = m_ctrl[1:0]; pol = m_ctrl[3:2]; casc = m_ctrl[4];
            act = casc ? (wcnt < wduty) : (ncnt[0] < nduty[0]);
            on[0] = en[0] ? (act ^ pol[0]) : pol[0];
            on[1] = (casc || !en[1]) ? pol[1] : ((ncnt[1] < nduty[1]) ^ pol[1]);
            for (int i = 0; i < 2; i++) begin
                if (!(en[i] && !casc)) begin
                    ncnt[i] = 0; nper[i] = m_per[i]; nduty[i] = m_duty[i];
                end else if (clk_en) begin
                    if (nper[i] == 0 || ncnt[i] + 1 >= nper[i]) begin
                        ncnt[i] = 0; nper[i] = m_per[i]; nduty[i] = m_duty[i];
                    end else ncnt[i] = ncnt[i] + 1;
                end
            end
            sp = m_per[1] * 256 + m_per[0];
            sd = m_duty[1] * 256 + m_duty[0];
            if (!(en[0] && casc)) begin
                wcnt = 0; wper = sp; wduty = sd;
            end else if (clk_en) begin
                if (wper == 0 || wcnt + 1 >= wper) begin
                    wcnt = 0; wper = sp; wduty = sd;
                end else wcnt = wcnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_per[0] = wr_data;
                    3'd1: m_duty[0] = wr_data;
                    3'd2: m_per[1] = wr_data;
                    3'd3: m_duty[1] = wr_data;
                    3'd4: m_ctrl = wr_data[4:0];
                    default: ;
                endcase
            end
            mout = on;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (pwm_o !== mout) begin
                errors++;
                $display("FAIL %s: pwm_o=%b expected %b at %0t", cur_req, pwm_o, mout, $time);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog (all R) expired: cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic count_high(input int b, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hi += int'(pwm_o[b]);
        end
    endtask

    task automatic count_edges(input int b, input int n, output int rises, output int flips);
        logic prev;
        @(negedge clk);
        prev = pwm_o[b]; rises = 0; flips = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o[b] != prev) flips++;
            if (pwm_o[b] && !prev) rises++;
            prev = pwm_o[b];
        end
    endtask

    initial begin
        int hi, rises, flips;
        logic prev;
        void'($urandom(32'h1D5A));

        // R1: reset state
        wait_n(4);
        cmp_on = 1'b1;
        check("R1 reset level", int'(pwm_o), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(3);
        check("R1 idle after reset", int'(pwm_o), 0);

        // R2/R3/R9: period 10, duty 3
        cur_req = "R3";
        wr(0, 10); wr(1, 3); wr(4, 8'h01);
        wait_n(25);
        count_high(0, 30, hi);      check("R3 duty 3 of 10", hi, 9);
        count_edges(0, 30, rises, flips); check("R2 period 10 rises", rises, 3);
        count_high(1, 20, hi);      check("R8 ch1 disabled low", hi, 0);

        // R9: unused addresses change nothing
        cur_req = "R9";
        wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
        wait_n(25);
        count_high(0, 30, hi);      check("R9 unused addr ignored", hi, 9);
        count_high(1, 10, hi);      check("R9 unused addr ch1", hi, 0);

        // R3: zero and saturating duty
        cur_req = "R3";
        wr(1, 0);   wait_n(25); count_high(0, 30, hi); check("R3 duty zero", hi, 0);
        wr(1, 10);  wait_n(25); count_high(0, 30, hi); check("R3 duty equals period", hi, 30);
        wr(1, 200); wait_n(25); count_high(0, 30, hi); check("R3 duty above period", hi, 30);

        // R5: polarity and idle level
        cur_req = "R5";
        wr(1, 3); wr(4, 8'h05);
        wait_n(25); count_high(0, 30, hi); check("R5 active-low duty 3", hi, 21);
        wr(4, 8'h04); wait_n(3);
        count_high(0, 10, hi); check("R5 disabled idles high", hi, 10);
        count_high(1, 10, hi); check("R5 ch1 idles low", hi, 0);

        // R2: period 0 is one tick
        cur_req = "R2";
        wr(0, 0); wr(1, 1); wr(4, 8'h01);
        wait_n(5); count_high(0, 10, hi); check("R2 period zero steady", hi, 10);

        // R4: tick gating
        cur_req = "R4";
        wr(0, 10); wr(1, 3);
        ce_mode = 1;
        wait_n(45); count_high(0, 40, hi); check("R4 half-rate ticks", hi, 12);
        ce_mode = 3;
        wait_n(3); count_edges(0, 15, rises, flips); check("R4 frozen without ticks", flips, 0);
        ce_mode = 0;

        // R6: new duty waits for the next period
        cur_req = "R6";
        wr(0, 20); wr(1, 10);
        wait_n(45);
        prev = pwm_o[0];
        do begin
            @(negedge clk);
            if (pwm_o[0] && !prev) break;
            prev = pwm_o[0];
        end while (1);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd2;
        hi = int'(pwm_o[0]);
        for (int k = 1; k < 20; k++) begin
            @(negedge clk);
            if (k == 1) wr_en = 1'b0;
            hi += int'(pwm_o[0]);
        end
        check("R6 period in progress keeps old duty", hi, 10);
        count_high(0, 20, hi); check("R6 next period uses new duty", hi, 2);

        // R8: independent channels
        cur_req = "R8";
        wr(0, 10); wr(1, 5); wr(2, 7); wr(3, 2); wr(4, 8'h03);
        wait_n(30);
        count_high(0, 70, hi); check("R8 ch0 duty 5 of 10", hi, 35);
        count_high(1, 70, hi); check("R8 ch1 duty 2 of 7", hi, 20);

        // R7: cascade, period 300 = {0x01,0x2C}, duty 100
        cur_req = "R7";
        wr(4, 8'h00);
        wr(0, 8'h2C); wr(2, 8'h01); wr(1, 8'h64); wr(3, 8'h00);
        wr(4, 8'h19);
        wait_n(350);
        count_high(0, 600, hi); check("R7 cascade duty 100 of 300", hi, 200);
        count_high(1, 50, hi);  check("R7 second pin parked high", hi, 50);
        wr(1, 8'h00); wr(3, 8'h01);
        wait_n(350);
        count_high(0, 600, hi); check("R7 cascade duty 256 of 300", hi, 512);

        // random phase against the model
        cur_req = "R6 random";
        ce_mode = 2;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom_range(0, 7));
                wr_data = (wr_addr == 3'd4) ? 8'($urandom_range(0, 31))
                                            : 8'($urandom_range(0, 24));
            end else wr_en = 1'b0;
        end
        @(negedge clk); wr_en = 1'b0;
        ce_mode = 0;

        // R1: reset clears polarity and output
        cur_req = "R1";
        wr(4, 8'h0C);
        wait_n(3);
        @(negedge clk); rst_n = 1'b0;
        wait_n(2);
        check("R1 reset clears outputs", int'(pwm_o), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(3);
        check("R1 polarity cleared by reset", int'(pwm_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule